// File: doc/BRIEF.md
# Clock-Synchronous Serial Transfer Unit

This block moves one byte at a time over a three-wire clocked serial link. A write places a byte in a transmit holding register. When the start conditions are met, the byte moves into a shift register and is clocked out on `txd`, least significant bit first. In the same eight clock periods the bits arriving on `rxd` are shifted in. A finished byte lands in a receive holding register, where the bus reads it.

The shift clock comes from one of two places. It can be made inside the block, by a prescaler (divide by 1, 8 or 32) followed by an 8-bit divider that gives a half period of `(n+1)` prescaled ticks. It can also be taken from `sck_in`, which is synchronised and edge-detected. A polarity bit sets the idle level of the clock. Optional flow control either holds off transmission while `cts_n` is high or drives `rts_n` to show that the receiver can accept a byte. Two one-cycle request pulses report transmit and receive events.

The transfer sequencer has five states. ST_IDLE holds the clock at its idle level and moves to ST_LOAD once the start condition holds. ST_LOAD copies the holding register into the shift register and always moves to ST_LEAD. ST_LEAD waits for a leading clock edge, drives the next bit and moves to ST_TRAIL. ST_TRAIL waits for a trailing edge and samples the input bit. It returns to ST_LEAD until eight bits are done, then moves to ST_DONE. ST_DONE stores the received byte, if reception was armed, and always returns to ST_IDLE.

Top module: `csio_unit`

## Requirements
- R1: After reset `txd` and `sck_out` are 1, `sck_oe` is 1, `rts_n` is 1, both request outputs are 0, and status (address 3) reads 0x01. Status bits are: bit0 transmit holding empty, bit1 busy, bit2 receive holding full, bit3 overrun, bit4 transmit request select.
- R2: A transfer sends exactly 8 bits, LSB first. Each new bit appears on `txd` at a leading clock edge. `rxd` is sampled at each trailing edge, and the received byte reads back at address 0. Reading address 0 with `bus_rd` empties the receive holding register.
- R3: With the internal clock, each clock half period lasts `(n+1)*P` cycles of `clk`. Here `n` is the divider byte at address 2 and P comes from control bits 5:4: 0 gives 1, 1 gives 8, 2 or 3 gives 32.
- R4: Control bit 3 is the polarity. The clock idles high when it is 0 and low when it is 1, and the leading edge always moves away from the idle level.
- R5: No transfer starts while control bit 0 (transmit enable) is 0, even with the transmit holding register loaded (address 0 written).
- R6: When control bits 7:6 are 1 (clear-to-send mode), no transfer starts while `cts_n` is high. A transfer starts once `cts_n` goes low.
- R7: Reception is armed only if control bit 1 (receive enable) is 1 when the transfer starts. Otherwise the receive holding register, its full flag and `rx_irq` are untouched.
- R8: With control bit 2 set (external clock), `sck_oe` is 0 and the shifting follows edges on `sck_in`. A transfer starts only while `sck_in` sits at its idle level.
- R9: With the request select (address 3 bit 0) at 0, `tx_irq` pulses for one cycle as the held byte moves into the shift register, before the first clock edge.
- R10: With the request select at 1, `tx_irq` pulses for one cycle after the 16th clock edge of the transfer.
- R11: `rx_irq` pulses for one cycle when a received byte is stored into an empty receive holding register. The full flag is set at the same time.
- R12: When a byte completes while the previous one is unread, the new byte overwrites the register, the overrun flag is set and `rx_irq` does not pulse. Clearing receive enable clears the overrun flag.
- R13: When control bits 7:6 are 2 (ready-to-send mode), `rts_n` is 0 exactly while receive enable is 1 and the receive holding register is empty. In every other mode `rts_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 data, 1 control, 2 divider, 3 misc/status |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; at address 0 it empties the receive holding register |
| bus_rdata | output | 8 | Read data for the selected register |
| sck_in | input | 1 | External shift clock |
| sck_out | output | 1 | Internally generated shift clock |
| sck_oe | output | 1 | High when `sck_out` should drive the clock line |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_n | output | 1 | Ready-to-send, active low |
| tx_irq | output | 1 | Transmit request pulse |
| rx_irq | output | 1 | Receive request pulse |

## Verification
The hardest situation to reach is a start that is held off while everything else is ready. The transmit byte is loaded, but `sck_in` sits at its active level, or `cts_n` is high, or transmit enable is 0. The stimulus loads the byte first and then holds the blocking input for hundreds of cycles while counting clock-line edges and reading status. Only after that does it release the input and let the scoreboard confirm the byte. The overrun case is reached by running two receiving transfers back to back with no read in between.

// File: rtl/csio_pkg.sv
package csio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LEAD,
        ST_TRAIL,
        ST_DONE
    } state_t;

    typedef enum logic [1:0] {
        FC_NONE = 2'd0,
        FC_CTS  = 2'd1,
        FC_RTS  = 2'd2,
        FC_OFF  = 2'd3
    } flow_t;

    typedef struct packed {
        flow_t      flow;
        logic [1:0] presc;
        logic       pol;
        logic       ext;
        logic       rx_en;
        logic       tx_en;
    } ctrl_t;

    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_CTRL = 2'd1;
    localparam logic [1:0] A_DIV  = 2'd2;
    localparam logic [1:0] A_MISC = 2'd3;

endpackage

// File: rtl/csio_sync.sv
module csio_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/csio_regs.sv
module csio_regs
    import csio_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic             load,
    output ctrl_t            ctrl,
    output logic [DIV_W-1:0] div_n,
    output logic             irq_sel,
    output logic [DW-1:0]    tx_buf,
    output logic             tx_full
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl    <= '0;
            div_n   <= '0;
            irq_sel <= 1'b0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                A_CTRL:  ctrl    <= ctrl_t'(bus_wdata[7:0]);
                A_DIV:   div_n   <= bus_wdata[DIV_W-1:0];
                A_MISC:  irq_sel <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_buf  <= '0;
            tx_full <= 1'b0;
        end else if (bus_wr && bus_addr == A_DATA) begin
            tx_buf  <= bus_wdata;
            tx_full <= 1'b1;
        end else if (load) begin
            tx_full <= 1'b0;
        end
    end
endmodule

// File: rtl/csio_clkgen.sv
module csio_clkgen #(
    parameter int DIV_W   = 8,
    parameter int PRE_MID = 8,
    parameter int PRE_MAX = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       presc,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick
);
    localparam int PW = $clog2(PRE_MAX);

    logic [PW-1:0]    pre_cnt;
    logic [PW-1:0]    pre_lim;
    logic [DIV_W-1:0] div_cnt;
    logic             pre_wrap;

    always_comb begin
        unique case (presc)
            2'd0:    pre_lim = '0;
            2'd1:    pre_lim = PW'(PRE_MID - 1);
            default: pre_lim = PW'(PRE_MAX - 1);
        endcase
    end

    assign pre_wrap = (pre_cnt == pre_lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (!run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (pre_wrap) begin
            pre_cnt <= '0;
            div_cnt <= (div_cnt == div_n) ? '0 : div_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    assign tick = run && pre_wrap && (div_cnt == div_n);
endmodule

// File: rtl/csio_engine.sv
module csio_engine
    import csio_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctrl_t         ctrl,
    input  logic          irq_sel,
    input  logic          tx_full,
    input  logic [DW-1:0] tx_buf,
    input  logic          tick,
    input  logic          sck_s,
    input  logic          rxd_s,
    input  logic          cts_s,
    output state_t        st,
    output logic          load,
    output logic          store,
    output logic [DW-1:0] store_data,
    output logic          run,
    output logic          sck_int,
    output logic          txd,
    output logic          tx_irq
);
    localparam int CW = $clog2(DW);

    state_t        nxt;
    logic [DW-1:0] sh;
    logic [CW-1:0] bit_cnt;
    logic          rx_act;
    logic          sck_q;
    logic          idle_lvl;
    logic          cts_ok;
    logic          ext_ok;
    logic          start;
    logic          lead_ev;
    logic          trail_ev;

    assign idle_lvl = ~ctrl.pol;
    assign cts_ok   = (ctrl.flow != FC_CTS) || !cts_s;
    assign ext_ok   = !ctrl.ext || (sck_s == idle_lvl);
    assign start    = ctrl.tx_en && tx_full && cts_ok && ext_ok;
    assign lead_ev  = ctrl.ext ? (sck_q == idle_lvl && sck_s != idle_lvl) : tick;
    assign trail_ev = ctrl.ext ? (sck_q != idle_lvl && sck_s == idle_lvl) : tick;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:  if (start) nxt = ST_LOAD;
            ST_LOAD:  nxt = ST_LEAD;
            ST_LEAD:  if (lead_ev) nxt = ST_TRAIL;
            ST_TRAIL: if (trail_ev) nxt = (bit_cnt == CW'(DW - 1)) ? ST_DONE : ST_LEAD;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh      <= '0;
            bit_cnt <= '0;
            rx_act  <= 1'b0;
            sck_int <= 1'b1;
            sck_q   <= 1'b0;
            txd     <= 1'b1;
            tx_irq  <= 1'b0;
        end else begin
            sck_q  <= sck_s;
            tx_irq <= 1'b0;
            unique case (st)
                ST_IDLE: sck_int <= idle_lvl;
                ST_LOAD: begin
                    sh      <= tx_buf;
                    bit_cnt <= '0;
                    rx_act  <= ctrl.rx_en;
                    tx_irq  <= !irq_sel;
                end
                ST_LEAD: if (lead_ev) begin
                    sck_int <= ~idle_lvl;
                    txd     <= sh[0];
                end
                ST_TRAIL: if (trail_ev) begin
                    sck_int <= idle_lvl;
                    sh      <= {rxd_s, sh[DW-1:1]};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                ST_DONE: tx_irq <= irq_sel;
                default: ;
            endcase
        end
    end

    assign load       = (st == ST_LOAD);
    assign store      = (st == ST_DONE) && rx_act;
    assign store_data = sh;
    assign run        = !ctrl.ext && (st == ST_LEAD || st == ST_TRAIL);
endmodule

// File: rtl/csio_rxbuf.sv
module csio_rxbuf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          store,
    input  logic [DW-1:0] store_data,
    input  logic          pop,
    input  logic          rx_en,
    output logic [DW-1:0] rx_buf,
    output logic          rx_full,
    output logic          overrun,
    output logic          rx_irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_buf  <= '0;
            rx_full <= 1'b0;
            overrun <= 1'b0;
            rx_irq  <= 1'b0;
        end else begin
            rx_irq <= 1'b0;
            if (store) begin
                rx_buf <= store_data;
                if (rx_full && !pop) begin
                    overrun <= 1'b1;
                end else begin
                    rx_full <= 1'b1;
                    rx_irq  <= 1'b1;
                end
            end else if (pop) begin
                rx_full <= 1'b0;
            end
            if (!rx_en) overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/csio_unit.sv
module csio_unit
    import csio_pkg::*;
#(
    parameter int DW      = 8,
    parameter int DIV_W   = 8,
    parameter int PRE_MID = 8,
    parameter int PRE_MAX = 32,
    parameter int SYNC_N  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_rd,
    output logic [DW-1:0] bus_rdata,
    input  logic          sck_in,
    output logic          sck_out,
    output logic          sck_oe,
    output logic          txd,
    input  logic          rxd,
    input  logic          cts_n,
    output logic          rts_n,
    output logic          tx_irq,
    output logic          rx_irq
);
    ctrl_t            ctrl;
    logic [DIV_W-1:0] div_n;
    logic             irq_sel;
    logic [DW-1:0]    tx_buf;
    logic             tx_full;
    logic             load;
    logic             store;
    logic [DW-1:0]    store_data;
    logic             run;
    logic             tick;
    logic             sck_int;
    state_t           st;
    logic [2:0]       pins_s;
    logic [DW-1:0]    rx_buf;
    logic             rx_full;
    logic             overrun;
    logic             pop;

    assign pop = bus_rd && (bus_addr == A_DATA);

    csio_regs #(.DW(DW), .DIV_W(DIV_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .load(load), .ctrl(ctrl), .div_n(div_n),
        .irq_sel(irq_sel), .tx_buf(tx_buf), .tx_full(tx_full)
    );

    csio_sync #(.W(3), .STAGES(SYNC_N)) i_sync (
        .clk(clk), .rst_n(rst_n), .d({cts_n, rxd, sck_in}), .q(pins_s)
    );

    csio_clkgen #(.DIV_W(DIV_W), .PRE_MID(PRE_MID), .PRE_MAX(PRE_MAX)) i_clkgen (
        .clk(clk), .rst_n(rst_n), .run(run), .presc(ctrl.presc),
        .div_n(div_n), .tick(tick)
    );

    csio_engine #(.DW(DW)) i_engine (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .irq_sel(irq_sel),
        .tx_full(tx_full), .tx_buf(tx_buf), .tick(tick),
        .sck_s(pins_s[0]), .rxd_s(pins_s[1]), .cts_s(pins_s[2]),
        .st(st), .load(load), .store(store), .store_data(store_data),
        .run(run), .sck_int(sck_int), .txd(txd), .tx_irq(tx_irq)
    );

    csio_rxbuf #(.DW(DW)) i_rxbuf (
        .clk(clk), .rst_n(rst_n), .store(store), .store_data(store_data),
        .pop(pop), .rx_en(ctrl.rx_en), .rx_buf(rx_buf), .rx_full(rx_full),
        .overrun(overrun), .rx_irq(rx_irq)
    );

    assign sck_out = sck_int;
    assign sck_oe  = !ctrl.ext;
    assign rts_n   = !(ctrl.flow == FC_RTS && ctrl.rx_en && !rx_full);

    always_comb begin
        unique case (bus_addr)
            A_DATA:  bus_rdata = rx_buf;
            A_CTRL:  bus_rdata = DW'(ctrl);
            A_DIV:   bus_rdata = DW'(div_n);
            default: bus_rdata = DW'({irq_sel, overrun, rx_full, (st != ST_IDLE), !tx_full});
        endcase
    end
endmodule

// File: rtl/csio_chk.sv
module csio_chk
    import csio_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input state_t st,
    input ctrl_t  ctrl,
    input logic   cts_s,
    input logic   sck_s,
    input logic   txd,
    input logic   sck_out,
    input logic   tx_irq,
    input logic   rx_irq,
    input logic   rx_full
);
    // R2
    txd_on_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.ext && txd != $past(txd)) |-> (sck_out != $past(sck_out)));

    // R4
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && $past(st) == ST_IDLE && $stable(ctrl.pol)) |-> (sck_out == !ctrl.pol));

    // R5
    no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !ctrl.tx_en) |=> (st != ST_LOAD));

    // R6
    cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && ctrl.flow == FC_CTS && cts_s) |=> (st != ST_LOAD));

    // R8
    ext_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && ctrl.ext && sck_s == ctrl.pol) |=> (st != ST_LOAD));

    // R9
    tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

    // R11
    rx_irq_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_full);
endmodule

bind csio_unit csio_chk i_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .ctrl(ctrl), .cts_s(pins_s[2]),
    .sck_s(pins_s[0]), .txd(txd), .sck_out(sck_out), .tx_irq(tx_irq),
    .rx_irq(rx_irq), .rx_full(rx_full)
);

// File: tb/test_csio_unit.sv
`timescale 1ns/1ps
module test_csio_unit;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [1:0] bus_addr = 0;
    logic       bus_wr = 0;
    logic [7:0] bus_wdata = 0;
    logic       bus_rd = 0;
    logic [7:0] bus_rdata;
    logic       sck_drv = 1;
    logic       sck_out, sck_oe, txd, rts_n, tx_irq, rx_irq;
    logic       rxd = 1;
    logic       cts_n = 0;

    int errors = 0, checks = 0;
    int edge_cnt = 0, lead_cnt = 0, trail_cnt = 0, done_cnt = 0;
    int half_cyc = 0, irq_edge = -1, txirq_cnt = 0, rxirq_cnt = 0;
    logic       ext_mode = 0, pol_b = 0, mon_on = 0;
    logic [7:0] slave_byte = 0, got;
    logic [7:0] exp_q[$];
    realtime    last_t = 0;
    logic       sck_line;

    always #2.5 clk = ~clk;
    assign sck_line = ext_mode ? sck_drv : sck_out;

    csio_unit i_csio_unit (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .sck_in(sck_drv), .sck_out(sck_out), .sck_oe(sck_oe), .txd(txd),
        .rxd(rxd), .cts_n(cts_n), .rts_n(rts_n), .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; #0.5; d = bus_rdata;
        if (a == 2'd0) bus_rd = 1;
        @(negedge clk); bus_rd = 0;
    endtask

    // driver: pushes the expected serial byte, then loads it
    task automatic start_xfer(input logic [7:0] tx, input logic [7:0] rxb);
        slave_byte = rxb;
        exp_q.push_back(tx);
        edge_cnt = 0;
        bus_write(2'd0, tx);
    endtask

    task automatic wait_done(input int target);
        while (done_cnt < target) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    task automatic quiet(input logic new_pol);
        mon_on = 0; repeat (4) @(negedge clk);
        pol_b = new_pol; mon_on = 1;
    endtask

    // monitor: watches the clock line, drives rxd, collects txd, compares
    initial forever begin
        @(sck_line);
        if (mon_on) begin
            #1;
            edge_cnt++;
            if (sck_line != ~pol_b) begin
                last_t = $realtime;
                rxd = slave_byte[lead_cnt];
                lead_cnt++;
            end else begin
                half_cyc = int'(($realtime - last_t) / 5.0);
                got[trail_cnt] = txd;
                trail_cnt++;
                if (trail_cnt == 8) begin
                    logic [7:0] e;
                    e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
                    check(got === e, "R2 serial byte on txd", got, e);
                    trail_cnt = 0; lead_cnt = 0; done_cnt++;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (tx_irq) begin txirq_cnt++; irq_edge = edge_cnt; end
        if (rx_irq) rxirq_cnt++;
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int rx_base;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(txd === 1 && sck_out === 1 && sck_oe === 1, "R1 pins", {txd, sck_out, sck_oe}, 3'b111);
        check(rts_n === 1 && tx_irq === 0 && rx_irq === 0, "R1 flags", {rts_n, tx_irq, rx_irq}, 3'b100);
        bus_read(2'd3, d); check(d == 8'h01, "R1 status", d, 8'h01);

        // R5: loaded but not enabled
        bus_write(2'd2, 8'd1);
        bus_write(2'd1, 8'h10);
        mon_on = 1;
        start_xfer(8'hA5, 8'h00);
        repeat (300) @(negedge clk);
        check(edge_cnt == 0, "R5 no edges while disabled", edge_cnt, 0);
        bus_read(2'd3, d); check(d == 8'h00, "R5 held status", d, 8'h00);
        bus_write(2'd1, 8'h11);
        wait_done(1);
        check(half_cyc == 16, "R3 half period n=1 P=8", half_cyc, 16);
        check(irq_edge == 0 && txirq_cnt == 1, "R9 tx request at load", irq_edge, 0);
        check(rxirq_cnt == 0, "R7 no receive request", rxirq_cnt, 0);
        bus_read(2'd3, d); check(d == 8'h01, "R7 receive buffer untouched", d, 8'h01);

        // R2 / R11: full duplex
        bus_write(2'd1, 8'h13);
        start_xfer(8'h3C, 8'hC6);
        wait_done(2);
        check(rxirq_cnt == 1, "R11 receive request", rxirq_cnt, 1);
        bus_read(2'd3, d); check(d == 8'h05, "R11 full flag", d, 8'h05);
        bus_read(2'd0, d); check(d == 8'hC6, "R2 received byte", d, 8'hC6);
        bus_read(2'd3, d); check(d == 8'h01, "R2 read empties", d, 8'h01);

        // R3: other rates
        bus_write(2'd2, 8'd5); bus_write(2'd1, 8'h01);
        start_xfer(8'h5A, 8'h00); wait_done(3);
        check(half_cyc == 6, "R3 half period n=5 P=1", half_cyc, 6);
        bus_write(2'd2, 8'd0); bus_write(2'd1, 8'h21);
        start_xfer(8'h81, 8'h00); wait_done(4);
        check(half_cyc == 32, "R3 half period n=0 P=32", half_cyc, 32);

        // R4: inverted polarity
        mon_on = 0;
        bus_write(2'd2, 8'd1); bus_write(2'd1, 8'h19);
        quiet(1);
        check(sck_out === 0, "R4 idle low", sck_out, 0);
        start_xfer(8'hE7, 8'h00); wait_done(5);
        check(sck_out === 0, "R4 idle low after transfer", sck_out, 0);

        // R10: request after last edge
        bus_write(2'd3, 8'h01);
        start_xfer(8'h42, 8'h00); wait_done(6);
        check(irq_edge == 16, "R10 tx request after 16 edges", irq_edge, 16);
        bus_write(2'd3, 8'h00);

        // R12: overrun
        mon_on = 0;
        bus_write(2'd1, 8'h13);
        quiet(0);
        rx_base = rxirq_cnt;
        start_xfer(8'h11, 8'h9A); wait_done(7);
        start_xfer(8'h22, 8'h7E); wait_done(8);
        check(rxirq_cnt == rx_base + 1, "R12 no request on overrun", rxirq_cnt, rx_base + 1);
        bus_read(2'd3, d); check(d == 8'h0D, "R12 overrun flag", d, 8'h0D);
        bus_read(2'd0, d); check(d == 8'h7E, "R12 overwritten byte", d, 8'h7E);
        bus_write(2'd1, 8'h11);
        bus_read(2'd3, d); check(d == 8'h01, "R12 overrun cleared", d, 8'h01);

        // R6: clear-to-send
        cts_n = 1;
        bus_write(2'd1, 8'h51);
        start_xfer(8'hB4, 8'h00);
        repeat (300) @(negedge clk);
        check(edge_cnt == 0, "R6 held by cts", edge_cnt, 0);
        bus_read(2'd3, d); check(d == 8'h00, "R6 held status", d, 8'h00);
        cts_n = 0;
        wait_done(9);
        bus_read(2'd3, d); check(d == 8'h01, "R6 sent after cts", d, 8'h01);

        // R13: ready-to-send
        bus_write(2'd1, 8'h93);
        check(rts_n === 0, "R13 ready when empty", rts_n, 0);
        start_xfer(8'h0F, 8'hF0); wait_done(10);
        check(rts_n === 1, "R13 not ready when full", rts_n, 1);
        bus_read(2'd0, d); check(d == 8'hF0, "R13 byte", d, 8'hF0);
        @(negedge clk);
        check(rts_n === 0, "R13 ready after read", rts_n, 0);
        bus_write(2'd1, 8'h13);
        check(rts_n === 1, "R13 other mode", rts_n, 1);

        // R8: external clock
        mon_on = 0;
        sck_drv = 0; ext_mode = 1;
        bus_write(2'd1, 8'h17);
        repeat (4) @(negedge clk);
        mon_on = 1;
        check(sck_oe === 0, "R8 clock not driven", sck_oe, 0);
        start_xfer(8'hD2, 8'h2D);
        repeat (100) @(negedge clk);
        bus_read(2'd3, d); check(d == 8'h00, "R8 held while clock active", d, 8'h00);
        mon_on = 0; sck_drv = 1; repeat (10) @(negedge clk); mon_on = 1;
        edge_cnt = 0;
        for (int i = 0; i < 8; i++) begin
            sck_drv = 0; repeat (8) @(negedge clk);
            sck_drv = 1; repeat (8) @(negedge clk);
        end
        wait_done(11);
        check(edge_cnt == 16, "R8 external edges", edge_cnt, 16);
        bus_read(2'd0, d); check(d == 8'h2D, "R8 received byte", d, 8'h2D);

        check(exp_q.size() == 0, "R2 all bytes seen", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule